// File: doc/BRIEF.md
# Set-Associative Translation Cache with Global Entries

This block keeps recently used virtual-page-to-physical-frame translations, with their permission bits, so that a translation request that hits is answered in the same cycle without touching memory. A lookup presents a virtual page number (VPN). The block returns a hit flag, the physical frame number (PFN) and four permission flags from combinational logic over its stored state. A page table walker outside the block installs new translations through a fill port. Three maintenance inputs control what is kept. The first drops every non-global translation when the address space changes. The second drops everything, including global entries. The third removes the single translation for one VPN.

Storage is arranged as `SETS` sets of `WAYS` ways (16 x 4 by default). The set is chosen by the low bits of the VPN and the remaining bits form the tag. A fill that finds its page already cached rewrites that way in place. Otherwise the fill takes the lowest-numbered empty way, or the way named by that set's round-robin pointer when the set is full. Two saturating counters record lookup hits and misses.

Back-pressure rules: the lookup port has no ready signal and takes a request on every cycle `lk_valid` is high. The fill port accepts a translation on a clock edge where `fill_valid` and `fill_ready` are both high. `fill_ready` is low in any cycle where a maintenance input is asserted. A walker holds its fill until it is accepted.

Top module: `xlat_cache`

## Requirements
- R1: While `lk_valid` is high, `lk_hit`, `lk_pfn` and `lk_flags` reflect the stored contents in the same cycle. `lk_hit` is low when `lk_valid` is low. `lk_pfn` and `lk_flags` are zero whenever `lk_hit` is low.
- R2: The set index is `vpn[IDX_W-1:0]` (bits 3:0 by default). Each set holds at most `WAYS` translations. Pages that map to different sets do not displace one another.
- R3: A fill accepted at a clock edge is visible to lookups from the next cycle. A lookup in the same cycle as the fill sees the contents from before the fill.
- R4: A fill for a VPN that is already cached overwrites that way with the new PFN and flags. It creates no second entry, evicts no other way and does not move the set's round-robin pointer.
- R5: A fill for an uncached VPN uses the lowest-numbered invalid way of its set. If the set is full, it uses the way named by the set's round-robin pointer, which starts at way 0 after reset and advances by one, wrapping, on each such eviction.
- R6: `flush_space` invalidates every entry whose global flag (`flags[3]`) is clear and keeps every global entry.
- R7: `flush_all` invalidates every entry, global or not.
- R8: `inv_valid` with `inv_vpn` invalidates only the entry matching that VPN. If the VPN is not cached, nothing changes.
- R9: `fill_ready` is low in any cycle where `flush_space`, `flush_all` or `inv_valid` is high, and a fill offered then is not taken. Otherwise `fill_ready` is high.
- R10: A maintenance input takes effect at the next clock edge. A lookup in the same cycle still sees the contents from before the maintenance operation.
- R11: `hit_count` increments on every cycle with `lk_valid` and a hit. `miss_count` increments on every cycle with `lk_valid` and no hit. Both stop at all ones.
- R12: After reset the cache is empty, both counters read zero and `fill_ready` is high.

Flag encoding: bit 0 writable, bit 1 user, bit 2 no-execute, bit 3 global.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| lk_flags | output | 4 | Permission flags on a hit, zero otherwise |
| fill_valid | input | 1 | Walker offers a translation |
| fill_ready | output | 1 | Fill can be taken this cycle |
| fill_vpn | input | VPN_W | Virtual page of the offered translation |
| fill_pfn | input | PFN_W | Frame of the offered translation |
| fill_flags | input | 4 | Flags of the offered translation |
| flush_space | input | 1 | Drop all non-global entries |
| flush_all | input | 1 | Drop all entries |
| inv_valid | input | 1 | Drop the entry for inv_vpn |
| inv_vpn | input | VPN_W | Page to drop |
| hit_count | output | CNT_W | Saturating hit count |
| miss_count | output | CNT_W | Saturating miss count |

## Verification
A lookup can fall in the same cycle as a maintenance operation or as a fill. The bench provokes both cases directly. It looks up a page while that page is being invalidated, and it looks up a page while its translation is being installed. In both cases it expects the answer from the old contents, with the change appearing one cycle later. It also offers a fill during an address-space flush and checks that `fill_ready` drops and that the page is still absent afterwards. A behavioural reference model, driven with the same stimulus, is compared against every output on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int FLAG_W   = 4;
  localparam int GLOB_BIT = 3;

  typedef struct packed {
    logic glob;
    logic noexec;
    logic user;
    logic writable;
  } xlat_flags_t;
endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int PFN_W = 20,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     wr_en_i,
  input  logic [IDX_W-1:0]                         wr_set_i,
  input  logic [WAY_W-1:0]                         wr_way_i,
  input  logic [TAG_W-1:0]                         wr_tag_i,
  input  logic [PFN_W-1:0]                         wr_pfn_i,
  input  logic [FLAG_W-1:0]                        wr_flags_i,
  input  logic                                     drop_local_i,
  input  logic                                     drop_every_i,
  input  logic                                     drop_one_i,
  input  logic [IDX_W-1:0]                         drop_set_i,
  input  logic [WAYS-1:0]                          drop_hit_i,
  output logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]     tags_o,
  output logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]     pfns_o,
  output logic [SETS-1:0][WAYS-1:0][FLAG_W-1:0]    flags_o,
  output logic [SETS-1:0][WAYS-1:0]                vld_o
);
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]  pfn_q;
  logic [SETS-1:0][WAYS-1:0][FLAG_W-1:0] flg_q;
  logic [SETS-1:0][WAYS-1:0]             vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q <= '0;
      pfn_q <= '0;
      flg_q <= '0;
      vld_q <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          if (drop_every_i) begin
            vld_q[s][w] <= 1'b0;
          end else begin
            if (drop_local_i && !flg_q[s][w][GLOB_BIT])
              vld_q[s][w] <= 1'b0;
            if (drop_one_i && (drop_set_i == IDX_W'(s)) && drop_hit_i[w])
              vld_q[s][w] <= 1'b0;
            if (wr_en_i && (wr_set_i == IDX_W'(s)) && (wr_way_i == WAY_W'(w))) begin
              vld_q[s][w] <= 1'b1;
              tag_q[s][w] <= wr_tag_i;
              pfn_q[s][w] <= wr_pfn_i;
              flg_q[s][w] <= wr_flags_i;
            end
          end
        end
      end
    end
  end

  assign tags_o  = tag_q;
  assign pfns_o  = pfn_q;
  assign flags_o = flg_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]                     set_i,
  input  logic [TAG_W-1:0]                     tag_i,
  input  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [SETS-1:0][WAYS-1:0]            vld_i,
  output logic [WAYS-1:0]                      hit_vec_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = vld_i[set_i][w] && (tags_i[set_i][w] == tag_i);
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int IDX_W = 4,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_i,
  input  logic [WAYS-1:0]  vld_i,
  input  logic [WAYS-1:0]  hit_vec_i,
  input  logic             alloc_i,
  output logic [WAY_W-1:0] way_o
);
  logic [SETS-1:0][WAY_W-1:0] ptr_q;
  logic                       any_hit;
  logic                       set_full;

  assign any_hit  = |hit_vec_i;
  assign set_full = &vld_i;

  always_comb begin
    way_o = ptr_q[set_i];
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!vld_i[w]) way_o = WAY_W'(w);
    end
    if (any_hit) begin
      for (int w = WAYS-1; w >= 0; w--) begin
        if (hit_vec_i[w]) way_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (alloc_i && !any_hit && set_full) begin
      if (ptr_q[set_i] == WAY_W'(WAYS-1)) ptr_q[set_i] <= '0;
      else                                ptr_q[set_i] <= ptr_q[set_i] + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_sat_ctr.sv
module xlat_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt_o <= '0;
    else if (inc_i && (cnt_o != '1)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  output logic [3:0]       lk_flags,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [3:0]       fill_flags,
  input  logic             flush_space,
  input  logic             flush_all,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tags;
  logic [SETS-1:0][WAYS-1:0][PFN_W-1:0]  pfns;
  logic [SETS-1:0][WAYS-1:0][FLAG_W-1:0] flgs;
  logic [SETS-1:0][WAYS-1:0]             vld;

  logic [IDX_W-1:0] lk_set, fl_set, iv_set;
  logic [TAG_W-1:0] lk_tag, fl_tag, iv_tag;
  logic [WAYS-1:0]  lk_hv, fl_hv, iv_hv;
  logic [WAY_W-1:0] fl_way;
  logic             lk_any, fill_go, maint;
  logic [PFN_W-1:0]  sel_pfn;
  logic [FLAG_W-1:0] sel_flg;

  assign lk_set = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set = fill_vpn[IDX_W-1:0];
  assign fl_tag = fill_vpn[VPN_W-1:IDX_W];
  assign iv_set = inv_vpn[IDX_W-1:0];
  assign iv_tag = inv_vpn[VPN_W-1:IDX_W];

  assign maint      = flush_space | flush_all | inv_valid;
  assign fill_ready = !maint;
  assign fill_go    = fill_valid && fill_ready;

  xlat_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PFN_W(PFN_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (fill_go),
    .wr_set_i     (fl_set),
    .wr_way_i     (fl_way),
    .wr_tag_i     (fl_tag),
    .wr_pfn_i     (fill_pfn),
    .wr_flags_i   (fill_flags),
    .drop_local_i (flush_space),
    .drop_every_i (flush_all),
    .drop_one_i   (inv_valid),
    .drop_set_i   (iv_set),
    .drop_hit_i   (iv_hv),
    .tags_o       (tags),
    .pfns_o       (pfns),
    .flags_o      (flgs),
    .vld_o        (vld)
  );

  xlat_match #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lk_match (
    .set_i(lk_set), .tag_i(lk_tag), .tags_i(tags), .vld_i(vld), .hit_vec_o(lk_hv)
  );
  xlat_match #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_fl_match (
    .set_i(fl_set), .tag_i(fl_tag), .tags_i(tags), .vld_i(vld), .hit_vec_o(fl_hv)
  );
  xlat_match #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_iv_match (
    .set_i(iv_set), .tag_i(iv_tag), .tags_i(tags), .vld_i(vld), .hit_vec_o(iv_hv)
  );

  xlat_victim #(.SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (fl_set),
    .vld_i     (vld[fl_set]),
    .hit_vec_i (fl_hv),
    .alloc_i   (fill_go),
    .way_o     (fl_way)
  );

  // One-hot by construction: a fill never creates a second copy of a tag.
  always_comb begin
    sel_pfn = '0;
    sel_flg = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lk_hv[w]) begin
        sel_pfn = sel_pfn | pfns[lk_set][w];
        sel_flg = sel_flg | flgs[lk_set][w];
      end
    end
  end

  assign lk_any   = |lk_hv;
  assign lk_hit   = lk_valid && lk_any;
  assign lk_pfn   = lk_hit ? sel_pfn : '0;
  assign lk_flags = lk_hit ? sel_flg : '0;

  xlat_sat_ctr #(.W(CNT_W)) u_hit_ctr (
    .clk(clk), .rst_n(rst_n), .inc_i(lk_hit), .cnt_o(hit_count)
  );
  xlat_sat_ctr #(.W(CNT_W)) u_miss_ctr (
    .clk(clk), .rst_n(rst_n), .inc_i(lk_valid && !lk_any), .cnt_o(miss_count)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [VPN_W-1:0] lk_vpn,
  input logic             lk_hit,
  input logic [PFN_W-1:0] lk_pfn,
  input logic [3:0]       lk_flags,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [VPN_W-1:0] fill_vpn,
  input logic [PFN_W-1:0] fill_pfn,
  input logic             flush_space,
  input logic             flush_all,
  input logic             inv_valid,
  input logic [VPN_W-1:0] inv_vpn,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  // R3
  fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready) |=>
      (!lk_valid || (lk_vpn != $past(fill_vpn)) || (lk_hit && (lk_pfn == $past(fill_pfn)))));

  // R6
  space_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_space |=> !(lk_hit && !lk_flags[3]));

  // R7
  all_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> !lk_hit);

  // R8
  page_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |=> !(lk_hit && (lk_vpn == $past(inv_vpn))));

  // R11
  hit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && (hit_count != {CNT_W{1'b1}})) |=> (hit_count == CNT_W'($past(hit_count) + 1'b1)));

  // R11
  miss_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit && (miss_count != {CNT_W{1'b1}})) |=>
      (miss_count == CNT_W'($past(miss_count) + 1'b1)));

  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> ((lk_pfn == '0) && (lk_flags == 4'd0)));
endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
  .lk_pfn(lk_pfn), .lk_flags(lk_flags), .fill_valid(fill_valid), .fill_ready(fill_ready),
  .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .flush_space(flush_space),
  .flush_all(flush_all), .inv_valid(inv_valid), .inv_vpn(inv_vpn),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int VW = 20;
  localparam int PW = 20;
  localparam int NS = 16;
  localparam int NW = 4;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, fill_valid = 0, flush_space = 0, flush_all = 0, inv_valid = 0;
  logic [VW-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [3:0]    fill_flags = '0;
  logic          lk_hit, fill_ready;
  logic [PW-1:0] lk_pfn;
  logic [3:0]    lk_flags;
  logic [CW-1:0] hit_count, miss_count;

  always #10 clk = ~clk;

  xlat_cache #(.VPN_W(VW), .PFN_W(PW), .SETS(NS), .WAYS(NW), .CNT_W(CW)) u_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_hit(lk_hit),
    .lk_pfn(lk_pfn), .lk_flags(lk_flags), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_flags(fill_flags),
    .flush_space(flush_space), .flush_all(flush_all), .inv_valid(inv_valid),
    .inv_vpn(inv_vpn), .hit_count(hit_count), .miss_count(miss_count)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;

  // behavioural reference model
  bit m_vld [NS][NW];
  int m_vpn [NS][NW];
  int m_pfn [NS][NW];
  int m_flg [NS][NW];
  int m_rr  [NS];
  int m_hits = 0, m_miss = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_find(input int vpn, output bit hit, output int pfn, output int flg, output int way);
    int s = vpn % NS;
    hit = 0; pfn = 0; flg = 0; way = -1;
    for (int w = 0; w < NW; w++)
      if (m_vld[s][w] && m_vpn[s][w] == vpn) begin
        hit = 1; pfn = m_pfn[s][w]; flg = m_flg[s][w]; way = w;
      end
  endtask

  task automatic m_update();
    bit h; int p, f, wy, s, pick;
    if (lk_valid) begin
      m_find(int'(lk_vpn), h, p, f, wy);
      if (h) begin if (m_hits < CMAX) m_hits++; end
      else   begin if (m_miss < CMAX) m_miss++; end
    end
    if (flush_all) begin
      foreach (m_vld[a, b]) m_vld[a][b] = 0;
    end else begin
      if (flush_space)
        foreach (m_vld[a, b]) if (((m_flg[a][b] >> 3) & 1) == 0) m_vld[a][b] = 0;
      if (inv_valid) begin
        m_find(int'(inv_vpn), h, p, f, wy);
        if (h) m_vld[int'(inv_vpn) % NS][wy] = 0;
      end
    end
    if (fill_valid && !(flush_space || flush_all || inv_valid)) begin
      s = int'(fill_vpn) % NS;
      m_find(int'(fill_vpn), h, p, f, wy);
      pick = -1;
      if (h) pick = wy;
      else begin
        for (int w = NW-1; w >= 0; w--) if (!m_vld[s][w]) pick = w;
        if (pick < 0) begin pick = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % NW; end
      end
      m_vld[s][pick] = 1;
      m_vpn[s][pick] = int'(fill_vpn);
      m_pfn[s][pick] = int'(fill_pfn);
      m_flg[s][pick] = int'(fill_flags);
    end
  endtask

  // compare every output against the model, then advance one clock
  task automatic step(input string tag);
    bit h; int p, f, wy;
    #2;
    m_find(int'(lk_vpn), h, p, f, wy);
    if (!lk_valid) begin h = 0; p = 0; f = 0; end
    check(lk_hit == h, {tag, " R1 hit"}, lk_hit, h);
    check(int'(lk_pfn) == p, {tag, " R1 pfn"}, lk_pfn, p);
    check(int'(lk_flags) == f, {tag, " R1 flags"}, lk_flags, f);
    check(fill_ready == !(flush_space || flush_all || inv_valid), {tag, " R9 ready"},
          fill_ready, !(flush_space || flush_all || inv_valid));
    check(int'(hit_count) == m_hits, {tag, " R11 hits"}, hit_count, m_hits);
    check(int'(miss_count) == m_miss, {tag, " R11 misses"}, miss_count, m_miss);
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic cyc(input bit lv, input int lvpn, input bit fv, input int fvpn, input int fpfn,
                     input int fflg, input bit fs, input bit fa, input bit iv, input int ivpn,
                     input string tag);
    lk_valid = lv; lk_vpn = VW'(lvpn);
    fill_valid = fv; fill_vpn = VW'(fvpn); fill_pfn = PW'(fpfn); fill_flags = 4'(fflg);
    flush_space = fs; flush_all = fa; inv_valid = iv; inv_vpn = VW'(ivpn);
    step(tag);
  endtask

  task automatic fill(input int vpn, input int pfn, input int flg, input string tag);
    cyc(0, 0, 1, vpn, pfn, flg, 0, 0, 0, 0, tag);
  endtask

  task automatic probe(input int vpn, input bit exp_hit, input int exp_pfn, input string tag);
    lk_valid = 1; lk_vpn = VW'(vpn);
    fill_valid = 0; flush_space = 0; flush_all = 0; inv_valid = 0;
    #1;
    check(lk_hit == exp_hit, {tag, " expect hit"}, lk_hit, exp_hit);
    if (exp_hit) check(int'(lk_pfn) == exp_pfn, {tag, " expect pfn"}, lk_pfn, exp_pfn);
    step(tag);
  endtask

  initial begin
    foreach (m_vld[a, b]) begin m_vld[a][b] = 0; m_vpn[a][b] = 0; m_pfn[a][b] = 0; m_flg[a][b] = 0; end
    foreach (m_rr[a]) m_rr[a] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: reset state
    check(fill_ready == 1'b1, "R12 ready", fill_ready, 1);
    check(hit_count == '0 && miss_count == '0, "R12 counters", hit_count, 0);
    probe('h00005, 0, 0, "R12");

    // R3, R10: lookup in the fill cycle sees old contents
    cyc(1, 'h00123, 1, 'h00123, 'hAAAAA, 'b0001, 0, 0, 0, 0, "R3");
    probe('h00123, 1, 'hAAAAA, "R3");

    // R5: fill set 3 through its empty ways, then evict round-robin
    fill('h00013, 'h0B0B0, 'b0011, "R5");
    fill('h00023, 'h0C0C0, 'b0101, "R5");
    fill('h00033, 'h0D0D0, 'b0001, "R5");
    fill('h00043, 'h0E0E0, 'b0001, "R5");   // full set: evicts way 0 (0x123)
    probe('h00123, 0, 0, "R5");
    probe('h00043, 1, 'h0E0E0, "R5");
    fill('h00053, 'h0F0F0, 'b0001, "R5");   // evicts way 1 (0x013)
    probe('h00013, 0, 0, "R5");
    probe('h00023, 1, 'h0C0C0, "R2");

    // R4: refill existing page in place
    fill('h00023, 'h12345, 'b0110, "R4");
    probe('h00023, 1, 'h12345, "R4");
    probe('h00033, 1, 'h0D0D0, "R4");
    probe('h00043, 1, 'h0E0E0, "R4");
    probe('h00053, 1, 'h0F0F0, "R4");
    fill('h00063, 'h06060, 'b0001, "R5");   // pointer at way 2: evicts 0x023
    probe('h00023, 0, 0, "R5");

    // R8, R10: invalidate with lookup of the same page in that cycle
    cyc(1, 'h00033, 0, 0, 0, 0, 0, 0, 1, 'h00033, "R10");
    probe('h00033, 0, 0, "R8");
    fill('h00073, 'h07070, 'b0001, "R5");   // freed way 3 used first
    probe('h00043, 1, 'h0E0E0, "R5");
    probe('h00073, 1, 'h07070, "R5");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 'h00999, "R8");   // absent page
    probe('h00053, 1, 'h0F0F0, "R8");
    probe('h00063, 1, 'h06060, "R8");

    // R2: one page per set, all coexist
    for (int s = 0; s < NS; s++) fill('h00200 + s, 'h30000 + s, 'b0001, "R2");
    for (int s = 0; s < NS; s++) probe('h00200 + s, 1, 'h30000 + s, "R2");

    // R6, R9: global entries survive; fill during the flush is refused
    fill('h00100, 'h55555, 'b1011, "R6");
    fill('h00101, 'h66666, 'b0010, "R6");
    cyc(1, 'h00101, 1, 'h00102, 'h77777, 'b0001, 1, 0, 0, 0, "R9");
    probe('h00100, 1, 'h55555, "R6");
    probe('h00101, 0, 0, "R6");
    probe('h00102, 0, 0, "R9");
    probe('h00073, 0, 0, "R6");
    probe('h00205, 0, 0, "R6");

    // R7
    cyc(1, 'h00100, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    probe('h00100, 0, 0, "R7");

    // R11: saturate both counters
    fill('h00444, 'h04444, 'b0001, "R11");
    for (int i = 0; i < 300; i++) begin
      probe('h00444, 1, 'h04444, "R11");
      probe('h00555, 0, 0, "R11");
    end
    check(int'(hit_count) == CMAX, "R11 hit saturate", hit_count, CMAX);
    check(int'(miss_count) == CMAX, "R11 miss saturate", miss_count, CMAX);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule